// File: doc/BRIEF.md
# PWM timer with half-cycle duty resolution

This block is a 16-bit up-counting timer that turns a count clock into a periodic square wave or PWM signal. Two compare values set the waveform. The period value fixes the length of one cycle. The duty value fixes the point at which the output switches to its active level. The counter runs from zero up to the period value and then starts again. Each restart returns the output to its idle level, so the active phase lasts from the duty point to the end of the period.

A half-step mode doubles the resolution of the duty point. In this mode the duty value counts half periods of the count clock. When the value is odd, the turn-on is held back to the falling edge of the count clock. The turn-off always stays on a rising edge. A polarity bit swaps the idle and active levels. Two strobes, one for each compare value, show where the counter stands, so the block can also drive an interrupt source without using its waveform.

Top module: `pwm_half_timer`

## Requirements
- R1: While `rst_n` is low, the counter is 0 and the output sits at its idle level, so `tmr_out` equals `out_inv`. Half-step mode is off unless `fine_en` is driven high.
- R2: While `run` is high and `preset` is low, the counter advances by one on each rising edge. On the edge after it equals `cmp_b` it goes back to 0, so one period lasts `cmp_b`+1 clocks.
- R3: In normal mode, on the rising edge after the counter equals `cmp_a`, the output goes active. On the rising edge after the counter equals `cmp_b`, it goes idle. This gives `cmp_b`-`cmp_a` active cycles per period. When both apply, idle wins.
- R4: `out_inv`=1 inverts `tmr_out` and changes no timing. The idle level is the value of `out_inv` and the active level is its complement.
- R5: When the effective duty point is larger than `cmp_b`, the output never goes active and `match_a` never pulses.
- R6: With `fine_en`=1, the effective duty point is `cmp_a`>>1. If `cmp_a` bit 0 is 1, the turn-on moves half a clock later, to the falling edge that follows the rising edge where it would otherwise occur. The turn-off is unchanged. The highest useful value is 2×`cmp_b`-1, which gives one half clock of active level per period.
- R7: With `fine_en`=1 and `cmp_a`=0, the waveform is the same as in normal mode with `cmp_a`=0.
- R8: `cmp_a`=0 and `cmp_b`=1 give an output at half the clock frequency: one clock active, one clock idle.
- R9: `match_a` is high while the counter equals the effective duty point. `match_b` is high while the counter equals `cmp_b`. Both strobes are high only while `run` is high and `preset` is low.
- R10: While `run` is low and `preset` is low, the counter and the output level hold their values.
- R11: `preset` high on a rising edge clears the counter and drives the output idle, whatever the state of `run`.
- R12: When the duty point equals `cmp_b`, both strobes still pulse in the same cycle and the output stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Count clock; both of its edges are used |
| rst_n | input | 1 | Asynchronous reset, active low |
| run | input | 1 | Count enable |
| preset | input | 1 | Synchronous clear of counter and output level |
| fine_en | input | 1 | Half-step duty mode select |
| out_inv | input | 1 | Output polarity swap |
| cmp_a | input | 16 | Duty point (half-clock units in half-step mode) |
| cmp_b | input | 16 | Period limit |
| tmr_out | output | 1 | Timer waveform |
| match_a | output | 1 | Strobe while counter equals the duty point |
| match_b | output | 1 | Strobe while counter equals the period limit |

## Verification
The hardest case to reach is the half-step turn-on. It is visible only in the half of the clock cycle after a rising edge, and only when half-step mode is on, the duty value is odd and the output has just become active. The stimulus sets odd duty values, including the largest one, 2×`cmp_b`-1, where the active phase is a single half clock. The outputs are sampled in both the high and the low phase of every clock, so a turn-on that comes half a cycle early or late shows up as a mismatch against the reference model. The same sweep runs with the polarity bit at both values, and also with even duty values, which must give exactly the same result as normal mode.

// File: rtl/pwmh_pkg.sv
package pwmh_pkg;

   // Output level before the polarity stage.
   typedef enum logic {
      LVL_IDLE = 1'b0,
      LVL_ACT  = 1'b1
   } level_e;

endpackage

// File: rtl/pwmh_counter.sv
module pwmh_counter #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         run,
   input  logic         preset,
   input  logic [W-1:0] limit,
   output logic [W-1:0] cnt,
   output logic         at_limit
);

   initial begin
      assert (W >= 2) else $error("pwmh_counter: W must be at least 2");
   end

   assign at_limit = (cnt == limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (preset)
         cnt <= '0;
      else if (run)
         cnt <= at_limit ? '0 : cnt + W'(1);
   end

   // R2: restart after the period limit
   a_r2_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      run && !preset && at_limit |=> cnt == '0);

   // R2: single step below the limit
   a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
      run && !preset && !at_limit |=> cnt == $past(cnt) + W'(1));

   // R10: stopped counter holds
   a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !run && !preset |=> $stable(cnt));

   // R11: preset clears
   a_r11_clear: assert property (@(posedge clk) disable iff (!rst_n)
      preset |=> cnt == '0);

endmodule

// File: rtl/pwmh_wave.sv
module pwmh_wave
   import pwmh_pkg::*;
#(
   parameter int W            = 16,
   parameter bit HALF_STEP_EN = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         run,
   input  logic         preset,
   input  logic [W-1:0] cnt,
   input  logic         at_limit,
   input  logic [W-1:0] a_pt,
   input  logic         a_half,
   output logic         on_lvl
);

   level_e on_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         on_q <= LVL_IDLE;
      else if (preset)
         on_q <= LVL_IDLE;
      else if (run) begin
         if (at_limit)
            on_q <= LVL_IDLE;
         else if (cnt == a_pt)
            on_q <= LVL_ACT;
      end
   end

   generate
      if (HALF_STEP_EN) begin : g_half
         level_e fall_q;

         // Copy of the level taken half a clock later.
         always_ff @(negedge clk or negedge rst_n) begin
            if (!rst_n)
               fall_q <= LVL_IDLE;
            else
               fall_q <= on_q;
         end

         assign on_lvl = a_half ? (on_q == LVL_ACT && fall_q == LVL_ACT)
                                : (on_q == LVL_ACT);

         // R6: odd duty value keeps the output idle until the falling edge
         a_r6_late_rise: assert property (@(negedge clk) disable iff (!rst_n)
            a_half && $rose(on_q == LVL_ACT) |-> !on_lvl);
      end else begin : g_full
         logic unused_half;
         assign unused_half = a_half;
         assign on_lvl = (on_q == LVL_ACT);
      end
   endgenerate

   // R3: restart forces idle
   a_r3_off_at_b: assert property (@(posedge clk) disable iff (!rst_n)
      run && !preset && at_limit |=> !on_lvl);

   // R3: duty match turns on
   a_r3_on_at_a: assert property (@(posedge clk) disable iff (!rst_n)
      run && !preset && !at_limit && cnt == a_pt |=> on_q == LVL_ACT);

   // R11: preset forces idle
   a_r11_idle: assert property (@(posedge clk) disable iff (!rst_n)
      preset |=> !on_lvl);

   // R10: stopped level holds
   a_r10_level: assert property (@(posedge clk) disable iff (!rst_n)
      !run && !preset |=> $stable(on_q));

endmodule

// File: rtl/pwm_half_timer.sv
module pwm_half_timer #(
   parameter int W            = 16,
   parameter bit HALF_STEP_EN = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         run,
   input  logic         preset,
   input  logic         fine_en,
   input  logic         out_inv,
   input  logic [W-1:0] cmp_a,
   input  logic [W-1:0] cmp_b,
   output logic         tmr_out,
   output logic         match_a,
   output logic         match_b
);

   logic [W-1:0] cnt;
   logic         at_limit;
   logic [W-1:0] a_pt;
   logic         a_half;
   logic         on_lvl;
   logic         live;

   initial begin
      assert (W >= 2) else $error("pwm_half_timer: W must be at least 2");
   end

   generate
      if (HALF_STEP_EN) begin : g_pt_half
         assign a_pt   = fine_en ? {1'b0, cmp_a[W-1:1]} : cmp_a;
         assign a_half = fine_en & cmp_a[0];
      end else begin : g_pt_full
         logic unused_fine;
         assign unused_fine = fine_en;
         assign a_pt   = cmp_a;
         assign a_half = 1'b0;
      end
   endgenerate

   pwmh_counter #(.W(W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run),
      .preset   (preset),
      .limit    (cmp_b),
      .cnt      (cnt),
      .at_limit (at_limit)
   );

   pwmh_wave #(.W(W), .HALF_STEP_EN(HALF_STEP_EN)) u_wave (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run),
      .preset   (preset),
      .cnt      (cnt),
      .at_limit (at_limit),
      .a_pt     (a_pt),
      .a_half   (a_half),
      .on_lvl   (on_lvl)
   );

   assign live    = run & ~preset;
   assign match_a = live & (cnt == a_pt);
   assign match_b = live & at_limit;
   assign tmr_out = on_lvl ^ out_inv;

   // R9: period strobe is followed by a restart
   a_r9_b_restart: assert property (@(posedge clk) disable iff (!rst_n)
      match_b |=> cnt == '0);

   // R12: duty point on the limit never shows the active level after restart
   a_r12_equal_idle: assert property (@(posedge clk) disable iff (!rst_n)
      match_a && match_b |=> tmr_out == out_inv);

endmodule

// File: tb/pwm_half_timer_test.sv
module pwm_half_timer_test;
   localparam int W = 16;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic         rst_n, run, preset, fine_en, out_inv;
   logic [W-1:0] cmp_a, cmp_b;
   logic         tmr_out, match_a, match_b;

   pwm_half_timer #(.W(W)) uut (
      .clk(clk), .rst_n(rst_n), .run(run), .preset(preset),
      .fine_en(fine_en), .out_inv(out_inv), .cmp_a(cmp_a), .cmp_b(cmp_b),
      .tmr_out(tmr_out), .match_a(match_a), .match_b(match_b)
   );

   int total = 0;
   int bad   = 0;
   string tag = "R1";

   int m_cnt = 0;
   bit m_on  = 0;
   bit m_vis = 0;
   int hi_cnt, lo_cnt, ma_seen, mb_seen;

   function automatic bit half_mode();
      return fine_en && cmp_a[0];
   endfunction

   function automatic int duty_pt();
      return fine_en ? int'(cmp_a >> 1) : int'(cmp_a);
   endfunction

   task automatic chk(string what, logic act, logic exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s act=%b exp=%b t=%0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic chk_int(string what, int act, int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s act=%0d exp=%0d t=%0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic compare(bit high_phase);
      bit live;
      live = run && !preset;
      chk("tmr_out", tmr_out, m_vis ^ out_inv);
      chk("R9 match_a", match_a, live && m_cnt == duty_pt());
      chk("R9 match_b", match_b, live && m_cnt == int'(cmp_b));
      if (high_phase) begin
         if (tmr_out) hi_cnt++;
         if (match_a) ma_seen++;
         if (match_b) mb_seen++;
      end else if (tmr_out) lo_cnt++;
   endtask

   // One clock: model update at the rising edge, checks in both phases.
   task automatic cyc();
      bit was_on;
      @(posedge clk);
      if (!rst_n) begin
         m_cnt = 0; m_on = 0; m_vis = 0;
      end else begin
         was_on = m_on;
         if (preset) begin
            m_cnt = 0; m_on = 0;
         end else if (run) begin
            if (m_cnt == int'(cmp_b)) begin
               m_cnt = 0; m_on = 0;
            end else begin
               if (m_cnt == duty_pt()) m_on = 1;
               m_cnt = (m_cnt + 1) & 16'hFFFF;
            end
         end
         if (!m_on)       m_vis = 0;
         else if (was_on) m_vis = 1;
         else             m_vis = !half_mode();
      end
      #5 compare(1'b1);
      @(negedge clk);
      if (rst_n) m_vis = m_on;
      #5 compare(1'b0);
   endtask

   task automatic setup(string t, bit f, bit inv, int a, int b);
      tag = t;
      fine_en = f; out_inv = inv; cmp_a = W'(a); cmp_b = W'(b);
      preset = 1; run = 1;
      cyc();
      preset = 0;
      hi_cnt = 0; lo_cnt = 0; ma_seen = 0; mb_seen = 0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      total++; bad++;
      $display("FAIL R1 watchdog act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      rst_n = 0; run = 0; preset = 0; fine_en = 0; out_inv = 1;
      cmp_a = 16'd2; cmp_b = 16'd5;
      tag = "R1";
      repeat (3) cyc();
      chk("R1 idle level", tmr_out, 1'b1);
      out_inv = 0;
      cyc();
      chk("R1 idle level", tmr_out, 1'b0);
      rst_n = 1;

      // R2 R3 normal PWM, two periods
      setup("R2 R3", 0, 0, 2, 5);
      repeat (12) cyc();
      chk_int("R3 active cycles", hi_cnt, 6);
      chk_int("R3 low-phase active", lo_cnt, 6);
      chk_int("R2 restarts", mb_seen, 2);
      chk_int("R9 duty strobes", ma_seen, 2);

      // R4 inverted polarity
      setup("R4", 0, 1, 1, 5);
      repeat (12) cyc();
      chk_int("R4 high cycles", hi_cnt, 4);

      // R8 minimum setting
      setup("R8", 0, 0, 0, 1);
      repeat (8) cyc();
      chk_int("R8 active cycles", hi_cnt, 4);
      chk_int("R8 restarts", mb_seen, 4);

      // R5 duty beyond the period
      setup("R5", 0, 0, 7, 4);
      repeat (15) cyc();
      chk_int("R5 active cycles", hi_cnt, 0);
      chk_int("R5 duty strobes", ma_seen, 0);
      setup("R5 R4", 0, 1, 9, 4);
      repeat (10) cyc();
      chk_int("R5 inverted high cycles", hi_cnt, 10);

      // R6 half-step odd duty
      setup("R6", 1, 0, 5, 5);
      repeat (12) cyc();
      chk_int("R6 high-phase active", hi_cnt, 4);
      chk_int("R6 low-phase active", lo_cnt, 6);
      setup("R6 R4", 1, 1, 3, 5);
      repeat (12) cyc();
      setup("R6 even", 1, 0, 4, 5);
      repeat (12) cyc();
      chk_int("R6 even high-phase", hi_cnt, 6);
      chk_int("R6 even low-phase", lo_cnt, 6);
      setup("R6 max", 1, 0, 5, 3);
      repeat (8) cyc();
      chk_int("R6 max high-phase", hi_cnt, 0);
      chk_int("R6 max low-phase", lo_cnt, 2);

      // R7 half-step with zero duty
      setup("R7", 1, 0, 0, 3);
      repeat (8) cyc();
      chk_int("R7 high-phase", hi_cnt, 6);
      chk_int("R7 low-phase", lo_cnt, 6);

      // R10 stop and hold
      setup("R10", 0, 0, 1, 5);
      repeat (3) cyc();
      run = 0;
      ma_seen = 0; mb_seen = 0; hi_cnt = 0;
      repeat (5) cyc();
      chk_int("R10 held active", hi_cnt, 5);
      chk_int("R10 strobes while stopped", ma_seen + mb_seen, 0);
      run = 1;
      repeat (6) cyc();

      // R11 preset while active, running and stopped
      setup("R11", 0, 0, 0, 7);
      repeat (4) cyc();
      preset = 1;
      cyc();
      chk("R11 idle after preset", tmr_out, 1'b0);
      preset = 0;
      repeat (3) cyc();
      run = 0; preset = 1;
      cyc();
      chk("R11 idle stopped preset", tmr_out, 1'b0);
      preset = 0; run = 1;
      repeat (4) cyc();

      // R12 duty point on the limit
      setup("R12", 0, 0, 3, 3);
      repeat (8) cyc();
      chk_int("R12 active cycles", hi_cnt, 0);
      chk_int("R12 duty strobes", ma_seen, 2);
      chk_int("R12 period strobes", mb_seen, 2);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule